// File: doc/BRIEF.md
# Opcode-menu SPI flash cycle sequencer

A register-programmed SPI flash master. Software fills an eight-entry menu of one-byte opcodes and gives each entry a two-bit cycle type. It then writes the control register with a menu index, an optional byte count and the go bit. The block runs exactly one flash cycle per go. The cycle is the selected opcode, then a 24-bit address when the type asks for one, then 1 to 64 data bytes. Write types take their data bytes from an on-chip buffer, and read types store the bytes they receive back into that buffer.

When the atomic bit is set and the prefix register holds a nonzero opcode, the block first sends that prefix alone in its own chip-select frame. It then sends the main command without releasing control of the bus. A write-enable ahead of a program or erase is the usual case. A lock bit freezes the menu, type and prefix registers until reset.

The SPI side runs in mode 0, MSB first. SCK is derived from the system clock through a divider that software sets in the control register.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0 and the status register reads 0. Chip select stays high whenever no cycle is in progress.
- R2: The bus runs in SPI mode 0. SCK idles low, every byte goes out MSB first, MOSI holds steady while SCK is high, and MISO is sampled on the rising SCK edge.
- R3: The opcode of a cycle is menu entry i, where i is control bits [6:4]. Entries 0..3 sit in register 5 and entries 4..7 in register 6, with entry k in bits [8(k%4)+7 : 8(k%4)]. The type of entry i is bits [2i+1:2i] of register 4. In the type, bit 1 set means the cycle has an address and bit 0 set means it is a write.
- R4: When the type has an address, the low 24 bits of register 2 follow the opcode as three bytes, most significant byte first.
- R5: When the data enable (control bit 14) is set, the cycle moves N+1 data bytes, where N is control bits [13:8]. Data byte k sits in buffer word k/4 (register 32+k/4), bits [8(k%4)+7 : 8(k%4)]. Write types send buffer bytes 0..N. Read types send 0x00 and store the received bytes into buffer bytes 0..N, leaving the other bytes unchanged.
- R6: When control bit 1 (atomic) is set and register 3 (prefix) is nonzero, the prefix byte is sent as a one-byte frame just before the main frame. When the prefix is zero, only the main frame is sent.
- R7: Between the prefix frame and the main frame, CS stays high for at least one SCK period.
- R8: Status (register 1) bit 0 is set while a cycle is in progress. Bit 1 (done) is set when a cycle ends and bit 2 (error) is set on a rejected cycle. Writing 1 to bit 1 or bit 2 clears that bit.
- R9: A write to the control register while a cycle is in progress is ignored. It neither starts a cycle nor changes the control fields.
- R10: Writing 1 to status bit 3 sets the lock bit, which reads back in bit 3. Once it is set, writes to the menu, type and prefix registers have no effect until reset. The address and data registers stay writable.
- R11: A go on a read-type entry with the data enable clear sets the error bit. No frame is driven and the done bit stays clear.
- R12: Each SCK high phase and each low phase lasts D+1 system clocks, where D is control bits [19:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| sck_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |

## Verification
The assertions assume that MISO changes only while SCK is low or at the falling edge of CS, as a mode-0 flash does. The bench's flash model changes MISO only on falling SCK edges and at the CS fall. The assertions also assume that the divider field does not change during a cycle. The bench always sets the divider together with go and never rewrites it while a cycle runs, except in the go-while-busy case, where the block must ignore the write anyway. Register writes are driven one per cycle on the falling clock edge, so every write is sampled cleanly.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int unsigned MENU_N = 8;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned DIV_W  = 4;
  localparam logic [REG_AW-1:0] A_CTRL = 6'd0;
  localparam logic [REG_AW-1:0] A_STAT = 6'd1;
  localparam logic [REG_AW-1:0] A_ADDR = 6'd2;
  localparam logic [REG_AW-1:0] A_PRE  = 6'd3;
  localparam logic [REG_AW-1:0] A_TYPE = 6'd4;
  localparam logic [REG_AW-1:0] A_MLO  = 6'd5;
  localparam logic [REG_AW-1:0] A_MHI  = 6'd6;
  localparam logic [REG_AW-1:0] A_DATA = 6'd32;

  typedef enum logic [1:0] {S_IDLE, S_START, S_SHIFT, S_GAP} seq_state_e;
endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 64,
  localparam int unsigned CNT_W = $clog2(DATA_BYTES),
  localparam int unsigned IDX_W = $clog2(DATA_BYTES + 5)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [7:0]       cfg_op_i,
  input  logic [1:0]       cfg_typ_i,
  input  logic [23:0]      cfg_addr_i,
  input  logic [7:0]       cfg_pre_i,
  input  logic             cfg_atomic_i,
  input  logic             cfg_den_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic             tick_i,
  output logic             tick_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] buf_rd_idx_o,
  input  logic [7:0]       buf_rd_byte_i,
  output logic             buf_we_o,
  output logic [CNT_W-1:0] buf_wr_idx_o,
  output logic [7:0]       buf_wr_byte_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  seq_state_e       state_q;
  logic [7:0]       op_q, pre_q, sh_out_q, sh_in_q;
  logic [1:0]       typ_q;
  logic [23:0]      addr_q;
  logic             den_q, in_pre_q, gap_q, sck_q, cs_n_q, done_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] idx_q;

  logic [IDX_W-1:0] hdr, data_n, last_idx, ld_idx, data_ld, data_cap;
  logic [7:0]       tx_byte;
  logic             byte_end;

  assign hdr      = typ_q[1] ? IDX_W'(4) : IDX_W'(1);
  assign data_n   = den_q ? IDX_W'(cnt_q) + IDX_W'(1) : '0;
  assign last_idx = in_pre_q ? '0 : hdr + data_n - IDX_W'(1);
  assign ld_idx   = (state_q == S_SHIFT) ? idx_q + IDX_W'(1) : '0;
  assign data_ld  = ld_idx - hdr;
  assign data_cap = idx_q - hdr;
  assign buf_rd_idx_o = data_ld[CNT_W-1:0];

  always_comb begin
    if (in_pre_q)              tx_byte = pre_q;
    else if (ld_idx == '0)     tx_byte = op_q;
    else if (ld_idx < hdr) begin
      case (ld_idx[1:0])
        2'd1:    tx_byte = addr_q[23:16];
        2'd2:    tx_byte = addr_q[15:8];
        default: tx_byte = addr_q[7:0];
      endcase
    end
    else if (typ_q[0])         tx_byte = buf_rd_byte_i;
    else                       tx_byte = 8'h00;
  end

  assign byte_end      = (state_q == S_SHIFT) && tick_i && sck_q && (bit_q == 3'd7);
  assign buf_we_o      = byte_end && !in_pre_q && !typ_q[0] && (idx_q >= hdr);
  assign buf_wr_idx_o  = data_cap[CNT_W-1:0];
  assign buf_wr_byte_o = sh_in_q;

  assign tick_en_o = (state_q == S_SHIFT) || (state_q == S_GAP);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign sck_o     = sck_q;
  assign cs_no     = cs_n_q;
  assign mosi_o    = sh_out_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  op_q <= '0;  pre_q <= '0;  typ_q <= '0;  addr_q <= '0;
      den_q <= 1'b0;      cnt_q <= '0; in_pre_q <= 1'b0; gap_q <= 1'b0;
      sck_q <= 1'b0;      cs_n_q <= 1'b1; sh_out_q <= '0; sh_in_q <= '0;
      bit_q <= '0;        idx_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (go_i) begin
          if (!cfg_typ_i[0] && !cfg_den_i) err_q <= 1'b1;  // read without data
          else begin
            op_q <= cfg_op_i;  typ_q <= cfg_typ_i;  addr_q <= cfg_addr_i;
            pre_q <= cfg_pre_i; den_q <= cfg_den_i; cnt_q <= cfg_cnt_i;
            in_pre_q <= cfg_atomic_i && (cfg_pre_i != 8'h00);
            state_q <= S_START;
          end
        end
        S_START: begin
          cs_n_q <= 1'b0;  sck_q <= 1'b0;  sh_out_q <= tx_byte;
          bit_q <= '0;     idx_q <= '0;    state_q <= S_SHIFT;
        end
        S_SHIFT: if (tick_i) begin
          if (!sck_q) begin
            sck_q   <= 1'b1;
            sh_in_q <= {sh_in_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (idx_q == last_idx) begin
                cs_n_q <= 1'b1;  gap_q <= 1'b0;  state_q <= S_GAP;
              end else begin
                idx_q <= idx_q + IDX_W'(1);  sh_out_q <= tx_byte;
              end
            end else begin
              bit_q    <= bit_q + 3'd1;
              sh_out_q <= {sh_out_q[6:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick_i) begin
          if (gap_q) begin
            if (in_pre_q) begin in_pre_q <= 1'b0; state_q <= S_START; end
            else begin state_q <= S_IDLE; done_q <= 1'b1; end
          end else gap_q <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 64,
  localparam int unsigned CNT_W  = $clog2(DATA_BYTES),
  localparam int unsigned WORDS  = DATA_BYTES / 4,
  localparam int unsigned WORD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic              go_o,
  output logic [7:0]        cfg_op_o,
  output logic [1:0]        cfg_typ_o,
  output logic [23:0]       cfg_addr_o,
  output logic [7:0]        cfg_pre_o,
  output logic              cfg_atomic_o,
  output logic              cfg_den_o,
  output logic [CNT_W-1:0]  cfg_cnt_o,
  output logic [DIV_W-1:0]  cfg_div_o,
  input  logic [CNT_W-1:0]  buf_rd_idx_i,
  output logic [7:0]        buf_rd_byte_o,
  input  logic              buf_we_i,
  input  logic [CNT_W-1:0]  buf_wr_idx_i,
  input  logic [7:0]        buf_wr_byte_i
);
  logic [MENU_N-1:0][7:0] menu_q;
  logic [15:0]            type_q;
  logic [7:0]             pre_q;
  logic [23:0]            addr_q;
  logic [2:0]             idx_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [DIV_W-1:0]       div_q;
  logic                   atomic_q, den_q, go_q, done_q, err_q, lock_q;
  logic [WORDS-1:0][31:0] buf_q;

  logic              blocked, wr_ctrl, wr_stat, in_data;
  logic [REG_AW-1:0] woff;
  logic [WORD_W-1:0] widx;

  assign blocked = busy_i || go_q;
  assign wr_ctrl = we_i && (addr_i == A_CTRL) && !blocked;
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign in_data = (addr_i >= A_DATA) && (int'(addr_i) < int'(A_DATA) + int'(WORDS));
  assign woff    = addr_i - A_DATA;
  assign widx    = woff[WORD_W-1:0];

  assign go_o         = go_q;
  assign cfg_op_o     = menu_q[idx_q];
  assign cfg_typ_o    = type_q[{idx_q, 1'b0} +: 2];
  assign cfg_addr_o   = addr_q;
  assign cfg_pre_o    = pre_q;
  assign cfg_atomic_o = atomic_q;
  assign cfg_den_o    = den_q;
  assign cfg_cnt_o    = cnt_q;
  assign cfg_div_o    = div_q;
  assign buf_rd_byte_o = buf_q[buf_rd_idx_i[CNT_W-1:2]][{buf_rd_idx_i[1:0], 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      menu_q <= '0; type_q <= '0; pre_q <= '0; addr_q <= '0; idx_q <= '0;
      cnt_q <= '0; div_q <= '0; atomic_q <= 1'b0; den_q <= 1'b0; go_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
    end else begin
      go_q <= wr_ctrl && wdata_i[0];
      if (wr_ctrl) begin
        atomic_q <= wdata_i[1];
        idx_q    <= wdata_i[6:4];
        cnt_q    <= wdata_i[8 +: CNT_W];
        den_q    <= wdata_i[14];
        div_q    <= wdata_i[16 +: DIV_W];
      end
      if (done_i)                    done_q <= 1'b1;
      else if (wr_stat && wdata_i[1]) done_q <= 1'b0;
      if (err_i)                     err_q <= 1'b1;
      else if (wr_stat && wdata_i[2]) err_q <= 1'b0;
      if (wr_stat && wdata_i[3])     lock_q <= 1'b1;
      if (we_i && addr_i == A_ADDR)  addr_q <= wdata_i[23:0];
      if (we_i && !lock_q) begin
        if (addr_i == A_PRE)  pre_q  <= wdata_i[7:0];
        if (addr_i == A_TYPE) type_q <= wdata_i[15:0];
        for (int i = 0; i < 4; i++) begin
          if (addr_i == A_MLO) menu_q[i]     <= wdata_i[8*i +: 8];
          if (addr_i == A_MHI) menu_q[i + 4] <= wdata_i[8*i +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= '0;
    else begin
      if (we_i && in_data) buf_q[widx] <= wdata_i;
      if (buf_we_i)
        buf_q[buf_wr_idx_i[CNT_W-1:2]][{buf_wr_idx_i[1:0], 3'b000} +: 8] <= buf_wr_byte_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_data) rdata_o = buf_q[widx];
    else begin
      case (addr_i)
        A_CTRL: begin
          rdata_o[1]            = atomic_q;
          rdata_o[6:4]          = idx_q;
          rdata_o[8 +: CNT_W]   = cnt_q;
          rdata_o[14]           = den_q;
          rdata_o[16 +: DIV_W]  = div_q;
        end
        A_STAT:  rdata_o[3:0]  = {lock_q, err_q, done_q, blocked};
        A_ADDR:  rdata_o[23:0] = addr_q;
        A_PRE:   rdata_o[7:0]  = pre_q;
        A_TYPE:  rdata_o[15:0] = type_q;
        A_MLO:   rdata_o       = {menu_q[3], menu_q[2], menu_q[1], menu_q[0]};
        A_MHI:   rdata_o       = {menu_q[7], menu_q[6], menu_q[5], menu_q[4]};
        default: rdata_o       = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 64,
  localparam int unsigned CNT_W = $clog2(DATA_BYTES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic             go, eng_busy, eng_done, eng_err, tick, tick_en, buf_we, atomic, den;
  logic [7:0]       op, pre, rd_byte, wr_byte;
  logic [1:0]       typ;
  logic [23:0]      addr;
  logic [CNT_W-1:0] cnt, rd_idx, wr_idx;
  logic [DIV_W-1:0] div;

  spi_seq_regs #(.DATA_BYTES(DATA_BYTES)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .busy_i(eng_busy), .done_i(eng_done), .err_i(eng_err),
    .go_o(go), .cfg_op_o(op), .cfg_typ_o(typ), .cfg_addr_o(addr), .cfg_pre_o(pre),
    .cfg_atomic_o(atomic), .cfg_den_o(den), .cfg_cnt_o(cnt), .cfg_div_o(div),
    .buf_rd_idx_i(rd_idx), .buf_rd_byte_o(rd_byte), .buf_we_i(buf_we),
    .buf_wr_idx_i(wr_idx), .buf_wr_byte_i(wr_byte)
  );

  spi_seq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(tick_en), .half_i(div), .tick_o(tick)
  );

  spi_seq_engine #(.DATA_BYTES(DATA_BYTES)) u_eng (
    .clk_i, .rst_ni, .go_i(go), .cfg_op_i(op), .cfg_typ_i(typ), .cfg_addr_i(addr),
    .cfg_pre_i(pre), .cfg_atomic_i(atomic), .cfg_den_i(den), .cfg_cnt_i(cnt),
    .tick_i(tick), .tick_en_o(tick_en), .busy_o(eng_busy), .done_o(eng_done),
    .err_o(eng_err), .buf_rd_idx_o(rd_idx), .buf_rd_byte_i(rd_byte), .buf_we_o(buf_we),
    .buf_wr_idx_o(wr_idx), .buf_wr_byte_o(wr_byte), .sck_o, .cs_no, .mosi_o, .miso_i
  );
endmodule

// File: rtl/spi_menu_seq_chk.sv
module spi_menu_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic done_i,
  input logic err_i,
  input logic cs_ni,
  input logic sck_i,
  input logic mosi_i
);
  // R1
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> cs_ni);
  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sck_i);
  // R2
  mosi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && sck_i && $past(sck_i)) |-> $stable(mosi_i));
  // R11
  err_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (cs_ni && !busy_i && !done_i));
  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && cs_ni && $past(busy_i)));
  // R7
  cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> cs_ni);
endmodule

bind spi_menu_seq spi_menu_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(eng_busy), .done_i(eng_done),
  .err_i(eng_err), .cs_ni(cs_no), .sck_i(sck_o), .mosi_i(mosi_o)
);

// File: tb/tb_spi_menu_seq.sv
`timescale 1ns/1ps
module tb_spi_menu_seq;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, miso = 1'b0;
  logic [5:0]  raddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, cs_n, mosi;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  spi_menu_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  typedef struct packed {
    logic [7:0] op; logic [1:0] typ; logic [23:0] adr; logic den; logic [5:0] cnt;
    logic atom; logic [2:0] idx; logic [7:0] pre; logic [3:0] div;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 2'd3, 24'h123456, 1'b1, 6'd3,  1'b1, 3'd2, 8'h06, 4'd0},
    '{8'h03, 2'd2, 24'hABCDEF, 1'b1, 6'd9,  1'b0, 3'd5, 8'h06, 4'd1},
    '{8'h05, 2'd0, 24'h000000, 1'b1, 6'd0,  1'b0, 3'd0, 8'h00, 4'd2},
    '{8'h01, 2'd1, 24'h000000, 1'b1, 6'd1,  1'b1, 3'd7, 8'h00, 4'd0},
    '{8'hD8, 2'd3, 24'h0F0000, 1'b0, 6'd0,  1'b1, 3'd3, 8'h06, 4'd3},
    '{8'h0B, 2'd2, 24'h00FF01, 1'b1, 6'd63, 1'b0, 3'd1, 8'h00, 4'd0}
  };

  function automatic logic [7:0] wb(int k); return 8'(8'hC3 ^ (k * 5)); endfunction
  function automatic logic [7:0] sf(int p); return 8'(p * 7 + 17); endfunction

  // flash model and frame recorder
  logic [7:0] frame_data [4][80];
  int frame_len [4];
  int frame_cnt = 0, cur = 0, spos = 0, sbit = 7, rbits = 0;
  logic [7:0] rx = '0, fv;
  int hi_run = 0, last_hi = 0, cs_run = 0, last_gap = -1;
  logic prev_cs = 1'b1;

  always @(negedge cs_n) begin
    spos = 0; sbit = 7; fv = sf(0); miso = fv[7];
    cur = frame_cnt; if (cur < 4) frame_len[cur] = 0;
    frame_cnt++; rbits = 0;
  end
  always @(posedge sck) if (cs_n === 1'b0) begin
    rx = {rx[6:0], mosi}; rbits++;
    if (rbits == 8) begin
      rbits = 0;
      if (cur < 4 && frame_len[cur] < 80) begin
        frame_data[cur][frame_len[cur]] = rx; frame_len[cur]++;
      end
    end
  end
  always @(negedge sck) if (cs_n === 1'b0) begin
    if (sbit == 0) begin sbit = 7; spos++; end else sbit--;
    fv = sf(spos); miso = fv[sbit];
  end
  always @(negedge clk) begin
    if (sck === 1'b1) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
    if (cs_n === 1'b1) cs_run++;
    else if (prev_cs === 1'b1) begin
      if (frame_cnt > 1) last_gap = cs_run;
      cs_run = 0;
    end
    prev_cs = cs_n;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; raddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a; #1 d = rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(6'd1, s);
      if (!s[0]) return;
    end
  endtask
  task automatic clear_frames();
    frame_cnt = 0; last_gap = -1;
    for (int i = 0; i < 4; i++) frame_len[i] = 0;
  endtask
  function automatic logic [31:0] mk_ctrl(logic go, logic atom, logic [2:0] idx,
                                          logic [5:0] cnt, logic den, logic [3:0] dv);
    return {12'd0, dv, 1'b0, den, cnt, 1'b0, idx, 2'b00, atom, go};
  endfunction

  logic [7:0] menu_sh [8];
  logic [1:0] typ_sh [8];

  task automatic run_vec(vec_t v);
    logic [31:0] s, tword, d;
    logic [7:0]  exp_b [80];
    int n, nf, bad, hdr;
    menu_sh[v.idx] = v.op; typ_sh[v.idx] = v.typ;
    tword = '0;
    for (int i = 0; i < 8; i++) tword[2*i +: 2] = typ_sh[i];
    wr(6'd5, {menu_sh[3], menu_sh[2], menu_sh[1], menu_sh[0]});
    wr(6'd6, {menu_sh[7], menu_sh[6], menu_sh[5], menu_sh[4]});
    wr(6'd4, tword);
    wr(6'd3, {24'd0, v.pre});
    wr(6'd2, {8'hFF, v.adr});
    for (int w = 0; w < 16; w++) wr(6'(32 + w), {wb(4*w+3), wb(4*w+2), wb(4*w+1), wb(4*w)});
    clear_frames();
    wr(6'd0, mk_ctrl(1'b1, v.atom, v.idx, v.cnt, v.den, v.div));
    wait_idle();
    nf = (v.atom && v.pre != 0) ? 2 : 1;
    chk("R6 frame count", frame_cnt, nf);
    if (nf == 2) begin
      chk("R6 prefix frame", {frame_len[0][23:0], frame_data[0][0]}, {24'd1, v.pre});
      chk("R7 cs gap at least one sck period", 32'(last_gap >= 2 * (int'(v.div) + 1)), 1);
    end
    hdr = v.typ[1] ? 4 : 1;
    n = 0; exp_b[n++] = v.op;
    if (v.typ[1]) begin exp_b[n++] = v.adr[23:16]; exp_b[n++] = v.adr[15:8]; exp_b[n++] = v.adr[7:0]; end
    if (v.den) for (int k = 0; k <= int'(v.cnt); k++) exp_b[n++] = v.typ[0] ? wb(k) : 8'h00;
    chk("R3 main frame length", frame_len[nf-1], n);
    bad = 0;
    for (int k = 0; k < n && k < frame_len[nf-1]; k++)
      if (frame_data[nf-1][k] !== exp_b[k]) bad++;
    chk("R2 R3 R4 R5 main frame bytes", bad, 0);
    chk("R12 sck half period", last_hi, int'(v.div) + 1);
    rd(6'd1, s);
    chk("R8 done after cycle", s, 32'h2);
    wr(6'd1, 32'h2);
    if (!v.typ[0]) begin
      bad = 0;
      for (int w = 0; w < 16; w++) begin
        rd(6'(32 + w), d);
        for (int b = 0; b < 4; b++) begin
          int k = 4*w + b;
          if (d[8*b +: 8] !== ((k <= int'(v.cnt)) ? sf(hdr + k) : wb(k))) bad++;
        end
      end
      chk("R5 read data stored in buffer", bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s, c;
    for (int i = 0; i < 8; i++) begin menu_sh[i] = '0; typ_sh[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 cs high in reset", cs_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'd1, s);
    chk("R1 status after reset", s, 32'h0);
    chk("R1 sck low after reset", {cs_n, sck}, 2'b10);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: read entry 0 (type 0) without data phase
    clear_frames();
    wr(6'd0, mk_ctrl(1'b1, 1'b0, 3'd0, 6'd0, 1'b0, 4'd0));
    repeat (40) @(negedge clk);
    rd(6'd1, s);
    chk("R11 error set, done clear", s, 32'h4);
    chk("R11 no frame driven", frame_cnt, 0);
    wr(6'd1, 32'h4);
    rd(6'd1, s);
    chk("R8 error cleared by write one", s, 32'h0);

    // R9: control write while busy is ignored
    clear_frames();
    wr(6'd0, mk_ctrl(1'b1, 1'b0, 3'd5, 6'd63, 1'b1, 4'd1));
    wr(6'd0, mk_ctrl(1'b1, 1'b1, 3'd2, 6'd2, 1'b1, 4'd0));
    rd(6'd1, s);
    chk("R8 busy during cycle", s[0], 1'b1);
    wait_idle();
    chk("R9 single frame", frame_cnt, 1);
    chk("R9 original cycle length", frame_len[0], 68);
    rd(6'd0, c);
    chk("R9 control fields kept", c, mk_ctrl(1'b0, 1'b0, 3'd5, 6'd63, 1'b1, 4'd1));
    wr(6'd1, 32'h2);

    // R10: lock
    wr(6'd1, 32'h8);
    wr(6'd5, 32'hFFFF_FFFF);
    wr(6'd4, 32'h0000_5555);
    wr(6'd3, 32'h77);
    wr(6'd2, 32'h00AA_BB11);
    rd(6'd5, c);
    chk("R10 menu locked", c, {menu_sh[3], menu_sh[2], menu_sh[1], menu_sh[0]});
    rd(6'd3, c);
    chk("R10 prefix locked", c, 32'h0);
    rd(6'd2, c);
    chk("R10 address still writable", c, 32'h00AA_BB11);
    rd(6'd1, s);
    chk("R10 lock bit reads back", s, 32'h8);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule